// File: doc/BRIEF.md
# Backplane Bus Arbiter with Grant Timeout

This block is the arbitration half of a backplane system controller. Four request levels arrive as active-low lines; the block picks one winner, drives exactly one active-low grant line, and then waits for the winner to take the bus by pulling the shared bus-busy line low. The selection policy is chosen at run time from three options: fixed priority, rotating round robin, and a single-level mode that serves only the top level.

A granted requester that never asserts bus-busy would stall the backplane. To prevent that, the block counts pulses of a one-microsecond tick input while a grant is outstanding. If the count reaches the selected window (16 or 256 ticks) before bus-busy appears, the grant is withdrawn, a sticky timeout flag is raised, and arbitration resumes. A board that is not the system controller holds the enable input low, which keeps every grant inactive.

Top module: `bus_arbiter_top`

## Requirements
- R1: While and after a synchronous reset, all four grant lines are high (inactive) and the timeout flag is 0.
- R2: At most one grant line is low at any time. With the block idle, enabled and bus-busy high, a request sampled at a clock edge produces its grant on that same edge (one cycle from request to visible grant).
- R3: With mode 2 or 3 (fixed priority), the highest-numbered requesting level wins: level 3 over 2, 2 over 1, 1 over 0.
- R4: With mode 0 (round robin), the search starts at the level one below the most recently granted level, goes downward and wraps from 0 to 3; the most recent level is checked last. After reset the most recent level counts as 0, so the first search starts at level 3.
- R5: With mode 1 (single level), only level 3 is served; requests on levels 0 to 2 produce no grant and do not change the round-robin history.
- R6: Once bus-busy (active low) is sampled low while a grant is outstanding, the grant goes high on that edge. No grant is issued while bus-busy is low; arbitration restarts on the edge after bus-busy is seen high again.
- R7: While a grant is outstanding without bus-busy, each high sample of the tick input advances a counter. When the counter equals the window (16 ticks with window_sel 0, 256 ticks with window_sel 1), the next edge drops the grant and sets the timeout flag. Without tick pulses no timeout occurs; bus-busy before the window ends prevents it.
- R8: The timeout flag stays at 1 until clr_timeout is sampled high, which clears it on that edge.
- R9: With enable low, an outstanding grant is withdrawn at the next edge and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | High when this block acts as system controller |
| mode | input | 2 | 0 round robin, 1 single level, 2 or 3 fixed priority |
| window_sel | input | 1 | Grant window: 0 = 16 ticks, 1 = 256 ticks |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| clr_timeout | input | 1 | Clears the sticky timeout flag |
| req_n | input | 4 | Active-low bus requests, bit i = level i |
| busy_n | input | 1 | Active-low bus-busy from the backplane |
| grant_n | output | 4 | Active-low registered grants, bit i = level i |
| timeout_flag | output | 1 | Sticky grant-timeout status |

## Verification
A grant is due one clock after its request is driven, and its withdrawal one clock after bus-busy goes low or enable goes low; the bench drives on the falling edge and samples on the next falling edge so each of these lands exactly one rising edge later. The timeout is due one edge after the window is filled, so with a tick on every cycle the grant stays visible for window+1 samples and the flag rises on the sample where the grant disappears; the bench counts those samples. Every request pattern is swept in every mode with the winner computed arithmetically from a tracked round-robin history.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    MODE_RR       = 2'd0,
    MODE_SINGLE   = 2'd1,
    MODE_PRIO     = 2'd2,
    MODE_PRIO_ALT = 2'd3
  } arb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_BUSY  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_select.sv
module arb_select
  import arb_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int IDX_W = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] req,
  input  logic [1:0]            mode,
  input  logic [IDX_W-1:0]      last,
  output logic                  hit,
  output logic [IDX_W-1:0]      win
);
  always_comb begin
    hit = 1'b0;
    win = '0;
    case (mode)
      MODE_SINGLE: begin
        if (req[NUM_LEVELS-1]) begin
          hit = 1'b1;
          win = IDX_W'(NUM_LEVELS-1);
        end
      end
      MODE_RR: begin
        // walk farthest candidate first so the nearest one overwrites
        for (int k = NUM_LEVELS; k >= 1; k--) begin
          int unsigned idx;
          idx = (int'(last) + NUM_LEVELS - k) % NUM_LEVELS;
          if (req[idx]) begin
            hit = 1'b1;
            win = IDX_W'(idx);
          end
        end
      end
      default: begin
        for (int i = 0; i < NUM_LEVELS; i++) begin
          if (req[i]) begin
            hit = 1'b1;
            win = IDX_W'(i);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/grant_timer.sv
module grant_timer #(
  parameter int SHORT_TICKS = 16,
  parameter int LONG_TICKS  = 256,
  localparam int CNT_W = $clog2(LONG_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic long_sel,
  output logic expired
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit   = long_sel ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick && (cnt < limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(LONG_TICKS));
endmodule

// File: rtl/bus_arbiter_top.sv
module bus_arbiter_top
  import arb_pkg::*;
#(
  parameter int NUM_LEVELS  = 4,
  parameter int SHORT_TICKS = 16,
  parameter int LONG_TICKS  = 256,
  localparam int IDX_W = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic [1:0]            mode,
  input  logic                  window_sel,
  input  logic                  us_tick,
  input  logic                  clr_timeout,
  input  logic [NUM_LEVELS-1:0] req_n,
  input  logic                  busy_n,
  output logic [NUM_LEVELS-1:0] grant_n,
  output logic                  timeout_flag
);
  arb_state_e              state;
  logic [NUM_LEVELS-1:0]   grant_q;
  logic [IDX_W-1:0]        last_q;
  logic                    to_flag_q;
  logic [NUM_LEVELS-1:0]   req_act;
  logic                    busy;
  logic                    hit;
  logic [IDX_W-1:0]        win;
  logic                    expired;

  assign req_act = ~req_n;
  assign busy    = ~busy_n;

  arb_select #(.NUM_LEVELS(NUM_LEVELS)) u_select (
    .req  (req_act),
    .mode (mode),
    .last (last_q),
    .hit  (hit),
    .win  (win)
  );

  grant_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (state == ST_GRANT),
    .tick     (us_tick),
    .long_sel (window_sel),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      grant_q   <= '0;
      last_q    <= '0;
      to_flag_q <= 1'b0;
    end else begin
      if (clr_timeout) to_flag_q <= 1'b0;
      if (!enable) begin
        state   <= ST_IDLE;
        grant_q <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (!busy && hit) begin
              grant_q <= NUM_LEVELS'(1) << win;
              last_q  <= win;
              state   <= ST_GRANT;
            end
          end
          ST_GRANT: begin
            if (busy) begin
              grant_q <= '0;
              state   <= ST_BUSY;
            end else if (expired) begin
              grant_q   <= '0;
              to_flag_q <= 1'b1;
              state     <= ST_IDLE;
            end
          end
          ST_BUSY: begin
            if (!busy) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign grant_n      = ~grant_q;
  assign timeout_flag = to_flag_q;

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~grant_n));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (&grant_n));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_n && (&grant_n)) |=> (&grant_n));

  // R7
  timeout_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && state == ST_GRANT && busy_n && expired) |=> (timeout_flag && (&grant_n)));

  // R5
  single_level_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SINGLE && (&grant_n)) |=> (&grant_n[NUM_LEVELS-2:0]));

  // R3
  prio_top_chk: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !req_n[NUM_LEVELS-1] && state == ST_IDLE && busy_n && enable)
      |=> !grant_n[NUM_LEVELS-1]);
endmodule

// File: tb/test_bus_arbiter_top.sv
module test_bus_arbiter_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic [1:0] mode;
  logic       window_sel;
  logic       us_tick;
  logic       clr_timeout;
  logic [3:0] req_n;
  logic       busy_n;
  logic [3:0] grant_n;
  logic       timeout_flag;

  int checks   = 0;
  int failures = 0;
  int last_m   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arbiter_top i_bus_arbiter_top (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode),
    .window_sel(window_sel), .us_tick(us_tick), .clr_timeout(clr_timeout),
    .req_n(req_n), .busy_n(busy_n), .grant_n(grant_n),
    .timeout_flag(timeout_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pick(input int m, input int pat, input int last, output bit hit);
    hit = 1'b0;
    if (m == 1) begin
      hit = pat[3];
      return 3;
    end
    if (m == 0) begin
      for (int k = 1; k <= 4; k++) begin
        int idx;
        idx = (last + 4 - k) % 4;
        if (pat[idx]) begin
          hit = 1'b1;
          return idx;
        end
      end
      return 0;
    end
    for (int i = 3; i >= 0; i--) begin
      if (pat[i]) begin
        hit = 1'b1;
        return i;
      end
    end
    return 0;
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Request pattern, check the expected grant, then complete with bus-busy.
  task automatic one_arb(input int m, input int pat, input string tag);
    bit hit;
    int w;
    w = pick(m, pat, last_m, hit);
    req_n = ~pat[3:0];
    cyc(1);
    if (hit) begin
      chk(grant_n == ~(4'b1 << w), tag, grant_n, ~(4'b1 << w));
      last_m = w;
      busy_n = 1'b0;
      cyc(1);
      chk(grant_n == 4'hF, "R6 drop on busy", grant_n, 4'hF);
      cyc(2);
      chk(grant_n == 4'hF, "R6 no grant while busy", grant_n, 4'hF);
      req_n  = 4'hF;
      busy_n = 1'b1;
      cyc(1);
    end else begin
      cyc(2);
      chk(grant_n == 4'hF, tag, grant_n, 4'hF);
      req_n = 4'hF;
      cyc(1);
    end
  endtask

  // Hold a request without bus-busy and count samples with the grant visible.
  task automatic measure_timeout(input bit long_w, input int expect_len, input string tag);
    int held;
    held = 0;
    window_sel = long_w;
    mode  = 2'd2;
    req_n = 4'b1101;
    cyc(1);
    while (grant_n != 4'hF && held < 1000) begin
      held++;
      cyc(1);
    end
    req_n = 4'hF;
    chk(held == expect_len, tag, held, expect_len);
    chk(timeout_flag == 1'b1, "R7 flag after timeout", timeout_flag, 1);
    cyc(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; enable = 1'b1; mode = 2'd2; window_sel = 1'b0;
    us_tick = 1'b1; clr_timeout = 1'b0; req_n = 4'hF; busy_n = 1'b1;
    cyc(3);
    chk(grant_n == 4'hF, "R1 reset grants", grant_n, 4'hF);
    chk(timeout_flag == 1'b0, "R1 reset flag", timeout_flag, 0);
    rst = 1'b0;
    cyc(1);

    // R4: first round-robin search after reset starts at level 3
    mode = 2'd0;
    for (int r = 0; r < 8; r++) one_arb(0, 15, "R4 rotation all requesting");

    // Sweep every pattern in every mode (R3, R4, R5, R2)
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      for (int p = 1; p < 16; p++) begin
        if (m == 0)      one_arb(m, p, "R4 round robin sweep");
        else if (m == 1) one_arb(m, p, "R5 single level sweep");
        else             one_arb(m, p, "R3 priority sweep");
      end
    end

    // R5: ignored requests leave round-robin history unchanged
    mode = 2'd1;
    one_arb(1, 7, "R5 low levels ignored");
    mode = 2'd0;
    one_arb(0, 15, "R5 history kept after ignored requests");

    // R6: busy held while idle blocks a new grant
    mode = 2'd2;
    busy_n = 1'b0;
    req_n  = 4'b1110;
    cyc(3);
    chk(grant_n == 4'hF, "R6 busy blocks grant", grant_n, 4'hF);
    busy_n = 1'b1;
    cyc(1);
    chk(grant_n == 4'b1110, "R6 restart after release", grant_n, 4'b1110);
    busy_n = 1'b0;
    cyc(1);
    req_n = 4'hF; busy_n = 1'b1;
    cyc(2);

    // R9: disable
    enable = 1'b0;
    req_n  = 4'h0;
    cyc(3);
    chk(grant_n == 4'hF, "R9 no grant when disabled", grant_n, 4'hF);
    enable = 1'b1;
    cyc(1);
    chk(grant_n == 4'b0111, "R9 grant after enable", grant_n, 4'b0111);
    enable = 1'b0;
    cyc(1);
    chk(grant_n == 4'hF, "R9 grant withdrawn", grant_n, 4'hF);
    req_n = 4'hF; enable = 1'b1;
    cyc(2);

    // R7 / R8: timeouts
    measure_timeout(1'b0, 17, "R7 short window length");
    clr_timeout = 1'b1;
    cyc(1);
    clr_timeout = 1'b0;
    chk(timeout_flag == 1'b0, "R8 clear", timeout_flag, 0);
    measure_timeout(1'b1, 257, "R7 long window length");
    cyc(5);
    chk(timeout_flag == 1'b1, "R8 flag sticky", timeout_flag, 1);
    clr_timeout = 1'b1;
    cyc(1);
    clr_timeout = 1'b0;
    chk(timeout_flag == 1'b0, "R8 clear again", timeout_flag, 0);

    // R7: busy before window end prevents timeout
    window_sel = 1'b0;
    req_n = 4'b1011;
    cyc(10);
    busy_n = 1'b0;
    cyc(1);
    chk(grant_n == 4'hF, "R7 busy before window", grant_n, 4'hF);
    req_n = 4'hF;
    cyc(30);
    chk(timeout_flag == 1'b0, "R7 no timeout when busy seen", timeout_flag, 0);
    busy_n = 1'b1;
    cyc(2);

    // R7: no ticks, no timeout
    us_tick = 1'b0;
    req_n = 4'b1011;
    cyc(300);
    chk(grant_n == 4'b1011, "R7 grant held without ticks", grant_n, 4'b1011);
    chk(timeout_flag == 1'b0, "R7 no flag without ticks", timeout_flag, 0);
    us_tick = 1'b1;
    cyc(17);
    chk(grant_n == 4'hF, "R7 timeout once ticks resume", grant_n, 4'hF);
    req_n = 4'hF;
    chk(timeout_flag == 1'b1, "R7 flag once ticks resume", timeout_flag, 1);
    cyc(2);

    finish_run();
  end
endmodule